// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a watchdog peripheral on a simple word-addressed register bus. It counts down in ticks, where each tick is a fixed number of bus clocks (in a real system, 10 ms). The count starts from a programmable 15-bit timeout. When a tick finds the count already at zero, the block drives a system reset pulse, marks a sticky timed-out status and reloads the count from the timeout. One tick earlier, when the count reaches zero, it raises a warning event. That event reaches the interrupt pin only when it is unmasked. A force bit can also drive the interrupt pin directly.

Every action that changes the run state needs a 16-bit key written to the right register:

| Action | Register offset | Key |
|---|---|---|
| Feed | 0x00 | 0xFEED |
| Resume | 0x1C | 0xACED |
| Clear status | 0x10 | 0xE8B4 |
| Stop | 0x08, then 0x0C | 0x2BAD, then 0xCAFE |

Software reads the remaining count through a mirror that takes a few cycles to settle. A debug-presence input pauses the countdown unless software has set a keep-running bit.

Three state machines make up the block:
- **Countdown machine:** `CD_OFF` goes to `CD_COUNT` on a resume key. `CD_COUNT` goes to `CD_OFF` on a completed stop sequence.
- **Stop-key machine:** `KS_IDLE` goes to `KS_ARMED` on the step-one key. `KS_ARMED` goes back to `KS_IDLE` on the step-two key (which stops the timer) or on any other write to either stop register. A repeated step-one key keeps it in `KS_ARMED`.
- **Pulse machine:** `PL_IDLE` goes to `PL_HOLD` on expiry. `PL_HOLD` goes back to `PL_IDLE` after `PULSE_CYC` cycles. A new expiry while in `PL_HOLD` starts the hold again.

Top module: `wdk_watchdog`

## Requirements
- R1: After reset:
  - the timer is stopped;
  - offset 0x0C reads 0xDABE and status (0x10) reads 0x0000;
  - timeout (0x04) and count (0x14) both read `INIT_TMO`;
  - the debug register (0x18) reads 0 while `dbg_present` is low;
  - `wd_rst_o` and `irq_o` are low.
- R2: A write of 0xFEED to 0x00 reloads the count from the timeout. Any other value written there leaves the count unchanged.
- R3: The timeout register (0x04) holds bits 14:0 of the written data. Bit 15 always reads 0.
- R4: Writing 0x2BAD to 0x08 and then 0xCAFE to 0x0C stops the timer. While stopped, 0x0C reads 0xDABE. While running, it reads 0x0000.
- R5: 0xCAFE written to 0x0C does not stop the timer when no 0x2BAD precedes it. It also does not stop the timer when another value was written to 0x08 or 0x0C after the 0x2BAD.
- R6: Writing 0xACED to 0x1C starts a stopped timer without reloading the count. A feed while stopped loads the count but does not start counting.
- R7: Timing of an expiry with timeout T, measured from a feed edge while running:
  - the reset pulse starts at tick T+1, that is `(T+1)*TICK_DIV` clocks after the feed;
  - it stays high for exactly `PULSE_CYC` clocks;
  - the count reloads to T at the same edge.
- R8: Status (0x10) reads 0xCFE8 from an expiry until 0xE8B4 is written there. Other values written there do not clear it.
- R9: Count (0x14) bits 14:0 give the settled remaining count. Bit 15 reads 1 while a new value is still propagating, for example right after a reload.
- R10: The event bit (bit 0 of 0x20) sets on the tick that brings the count to zero, one tick before expiry. Writing 1 to bit 0 of 0x20 clears it; writing 0 does not. `irq_o` is the event gated by mask bit 0 of 0x24.
- R11: Force bit 0 of 0x28 drives `irq_o` high while mask bit 0 is set, even with no event pending.
- R12: While `dbg_present` is high and keep bit 0 of 0x18 is clear, the countdown is frozen. Setting the keep bit resumes it. Bit 1 of 0x18 reads `dbg_present`.
- R13: A timeout of 0 expires at the first tick after a feed and raises no warning event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 6 | Byte address (word aligned) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| dbg_present | input | 1 | Debugger attached indication |
| wd_rst_o | output | 1 | System reset pulse |
| irq_o | output | 1 | Early-warning interrupt |

## Verification
The bench builds the block with the following parameters:

| Parameter | Value |
|---|---|
| `TICK_DIV` | 8 |
| `PULSE_CYC` | 4 |
| `SETTLE_CYC` | 3 |
| `INIT_TMO` | 5 |

With these values a full warning-then-expiry cycle at timeout 2 spans only 24 clocks. This lets every edge of the warning, the reset pulse and its end be sampled at an exact cycle. The short settle time lets the busy bit be seen right after a reload, and the settled count still arrives within a few reads. The small `INIT_TMO` makes the reset value distinct from the all-ones timeout that later tests program.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
    localparam int TMO_W  = 15;
    localparam int DATA_W = 16;

    localparam logic [3:0] IX_FEED   = 4'd0;
    localparam logic [3:0] IX_TMO    = 4'd1;
    localparam logic [3:0] IX_STOP_A = 4'd2;
    localparam logic [3:0] IX_STOP_B = 4'd3;
    localparam logic [3:0] IX_STAT   = 4'd4;
    localparam logic [3:0] IX_CNT    = 4'd5;
    localparam logic [3:0] IX_DBG    = 4'd6;
    localparam logic [3:0] IX_RESUME = 4'd7;
    localparam logic [3:0] IX_EVT    = 4'd8;
    localparam logic [3:0] IX_MASK   = 4'd9;
    localparam logic [3:0] IX_FORCE  = 4'd10;
    localparam logic [3:0] IX_NONE   = 4'd15;

    localparam logic [DATA_W-1:0] K_FEED    = 16'hFEED;
    localparam logic [DATA_W-1:0] K_STOP_A  = 16'h2BAD;
    localparam logic [DATA_W-1:0] K_STOP_B  = 16'hCAFE;
    localparam logic [DATA_W-1:0] K_RESUME  = 16'hACED;
    localparam logic [DATA_W-1:0] K_CLEAR   = 16'hE8B4;
    localparam logic [DATA_W-1:0] C_STOPPED = 16'hDABE;
    localparam logic [DATA_W-1:0] C_RUNNING = 16'h0000;
    localparam logic [DATA_W-1:0] C_EXPIRED = 16'hCFE8;
    localparam logic [DATA_W-1:0] C_NORMAL  = 16'h0000;

    typedef enum logic {CD_OFF, CD_COUNT} cd_state_e;
    typedef enum logic {KS_IDLE, KS_ARMED} key_state_e;
    typedef enum logic {PL_IDLE, PL_HOLD} pulse_state_e;
endpackage

// File: rtl/wdk_tick_gen.sv
module wdk_tick_gen #(
    parameter int TICK_DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic clr_i,
    output logic tick_o
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] presc_q;

    assign tick_o = run_i && (presc_q == LAST);

    // Prescaler restarts on every reload so tick k lands k*TICK_DIV clocks later
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            presc_q <= '0;
        else if (clr_i || !run_i || tick_o)
            presc_q <= '0;
        else
            presc_q <= presc_q + 1'b1;
    end
endmodule

// File: rtl/wdk_countdown.sv
module wdk_countdown
    import wdk_pkg::*;
#(
    parameter int                PULSE_CYC  = 64,
    parameter logic [TMO_W-1:0]  INIT_COUNT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             feed_i,
    input  logic             resume_i,
    input  logic             halt_i,
    input  logic             hold_i,
    input  logic             tick_i,
    input  logic [TMO_W-1:0] timeout_i,
    output logic [TMO_W-1:0] count_o,
    output logic             counting_o,
    output logic             run_o,
    output logic             warn_o,
    output logic             expire_o,
    output logic             wd_rst_o
);
    localparam int LW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
    localparam logic [LW-1:0] PLAST = LW'(PULSE_CYC - 1);

    cd_state_e    st_q, st_d;
    pulse_state_e pl_q, pl_d;
    logic [LW-1:0]    len_q, len_d;
    logic [TMO_W-1:0] count_q;

    // Countdown state transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CD_OFF:   if (resume_i) st_d = CD_COUNT;
            CD_COUNT: if (halt_i)   st_d = CD_OFF;
        endcase
    end

    // Reset pulse state transitions
    always_comb begin
        pl_d  = pl_q;
        len_d = len_q;
        unique case (pl_q)
            PL_IDLE: begin
                if (expire_o) begin
                    pl_d  = PL_HOLD;
                    len_d = PLAST;
                end
            end
            PL_HOLD: begin
                if (expire_o) begin
                    len_d = PLAST;
                end else if (len_q == '0) begin
                    pl_d = PL_IDLE;
                end else begin
                    len_d = len_q - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= CD_OFF;
            pl_q  <= PL_IDLE;
            len_q <= '0;
        end else begin
            st_q  <= st_d;
            pl_q  <= pl_d;
            len_q <= len_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_q <= INIT_COUNT;
        else if (feed_i || expire_o)
            count_q <= timeout_i;
        else if (tick_i)
            count_q <= count_q - 1'b1;
    end

    // Outputs
    always_comb begin
        counting_o = (st_q == CD_COUNT);
        run_o      = counting_o && !hold_i;
        warn_o     = tick_i && !feed_i && (count_q == TMO_W'(1));
        expire_o   = tick_i && !feed_i && (count_q == '0);
        wd_rst_o   = (pl_q == PL_HOLD);
        count_o    = count_q;
    end

    // R7: a reset pulse only ever starts out of the counting state
    a_r7_pulse_from_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_rst_o) |-> $past(st_q == CD_COUNT));

    // R6: a stopped timer leaves its count alone except on a feed
    a_r6_off_no_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q == CD_OFF) && !$past(feed_i)) |-> $stable(count_q));
endmodule

// File: rtl/wdk_count_mirror.sv
module wdk_count_mirror
    import wdk_pkg::*;
#(
    parameter int               SETTLE_CYC = 4,
    parameter logic [TMO_W-1:0] INIT_COUNT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TMO_W-1:0]  live_i,
    output logic [DATA_W-1:0] view_o
);
    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam logic [SW-1:0] SLOAD = SW'(SETTLE_CYC);

    logic [TMO_W-1:0] shadow_q;
    logic [SW-1:0]    settle_q;
    logic             busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= INIT_COUNT;
            settle_q <= '0;
        end else if (settle_q != '0) begin
            settle_q <= settle_q - 1'b1;
            if (settle_q == SW'(1))
                shadow_q <= live_i;
        end else if (live_i != shadow_q) begin
            settle_q <= SLOAD;
        end
    end

    assign busy   = (settle_q != '0) || (live_i != shadow_q);
    assign view_o = {busy, shadow_q};

    // R9: the visible count only moves at the end of a settling window
    a_r9_shadow_moves_on_settle: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(shadow_q) |-> ($past(settle_q) == SW'(1)));
endmodule

// File: rtl/wdk_regs.sv
module wdk_regs
    import wdk_pkg::*;
#(
    parameter logic [TMO_W-1:0] INIT_TMO = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [5:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              dbg_i,
    input  logic              counting_i,
    input  logic              warn_i,
    input  logic              expire_i,
    input  logic [DATA_W-1:0] count_view_i,
    output logic              feed_o,
    output logic              resume_o,
    output logic              halt_o,
    output logic [TMO_W-1:0]  timeout_o,
    output logic              keep_o,
    output logic              irq_o
);
    key_state_e ks_q, ks_d;
    logic [3:0] sel;
    logic       wr_a, wr_b;
    logic [TMO_W-1:0] tmo_q;
    logic stat_q, evt_q, mask_q, force_q, keep_q;

    assign sel  = (addr_i[1:0] == 2'b00) ? addr_i[5:2] : IX_NONE;
    assign wr_a = we_i && (sel == IX_STOP_A);
    assign wr_b = we_i && (sel == IX_STOP_B);

    assign feed_o   = we_i && (sel == IX_FEED)   && (wdata_i == K_FEED);
    assign resume_o = we_i && (sel == IX_RESUME) && (wdata_i == K_RESUME);

    // Two-step stop key sequencer
    always_comb begin
        ks_d   = ks_q;
        halt_o = 1'b0;
        unique case (ks_q)
            KS_IDLE: begin
                if (wr_a && wdata_i == K_STOP_A) ks_d = KS_ARMED;
            end
            KS_ARMED: begin
                if (wr_b && wdata_i == K_STOP_B) begin
                    halt_o = 1'b1;
                    ks_d   = KS_IDLE;
                end else if (wr_a && wdata_i == K_STOP_A) begin
                    ks_d = KS_ARMED;
                end else if (wr_a || wr_b) begin
                    ks_d = KS_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ks_q <= KS_IDLE;
        else        ks_q <= ks_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmo_q   <= INIT_TMO;
            stat_q  <= 1'b0;
            evt_q   <= 1'b0;
            mask_q  <= 1'b0;
            force_q <= 1'b0;
            keep_q  <= 1'b0;
        end else begin
            if (we_i && sel == IX_TMO)   tmo_q   <= wdata_i[TMO_W-1:0];
            if (we_i && sel == IX_MASK)  mask_q  <= wdata_i[0];
            if (we_i && sel == IX_FORCE) force_q <= wdata_i[0];
            if (we_i && sel == IX_DBG)   keep_q  <= wdata_i[0];
            if (expire_i)
                stat_q <= 1'b1;
            else if (we_i && sel == IX_STAT && wdata_i == K_CLEAR)
                stat_q <= 1'b0;
            if (warn_i)
                evt_q <= 1'b1;
            else if (we_i && sel == IX_EVT && wdata_i[0])
                evt_q <= 1'b0;
        end
    end

    always_comb begin
        case (sel)
            IX_TMO:    rdata_o = {1'b0, tmo_q};
            IX_STOP_B: rdata_o = counting_i ? C_RUNNING : C_STOPPED;
            IX_STAT:   rdata_o = stat_q ? C_EXPIRED : C_NORMAL;
            IX_CNT:    rdata_o = count_view_i;
            IX_DBG:    rdata_o = {14'd0, dbg_i, keep_q};
            IX_EVT:    rdata_o = {15'd0, evt_q};
            IX_MASK:   rdata_o = {15'd0, mask_q};
            IX_FORCE:  rdata_o = {15'd0, force_q};
            default:   rdata_o = '0;
        endcase
    end

    assign timeout_o = tmo_q;
    assign keep_o    = keep_q;
    assign irq_o     = mask_q && (evt_q || force_q);

    // R8: timed-out status holds until the clear key or a fresh expiry
    a_r8_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q && !(we_i && sel == IX_STAT && wdata_i == K_CLEAR)) |=> stat_q);

    // R10: the event bit only rises after a warning tick
    a_r10_event_from_warn: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_q) |-> $past(warn_i));
endmodule

// File: rtl/wdk_watchdog.sv
module wdk_watchdog
    import wdk_pkg::*;
#(
    parameter int TICK_DIV   = 1000,
    parameter int PULSE_CYC  = 64,
    parameter int SETTLE_CYC = 4,
    parameter int INIT_TMO   = 6000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [5:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        dbg_present,
    output logic        wd_rst_o,
    output logic        irq_o
);
    localparam logic [TMO_W-1:0] INIT_V = TMO_W'(INIT_TMO);

    logic feed, resume, halt, keep, hold, tick, run, counting, warn, expire;
    logic [TMO_W-1:0]  timeout, count;
    logic [DATA_W-1:0] count_view;

    assign hold = dbg_present && !keep;

    wdk_regs #(.INIT_TMO(INIT_V)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(bus_we), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .rdata_o(bus_rdata), .dbg_i(dbg_present),
        .counting_i(counting), .warn_i(warn), .expire_i(expire),
        .count_view_i(count_view), .feed_o(feed), .resume_o(resume),
        .halt_o(halt), .timeout_o(timeout), .keep_o(keep), .irq_o(irq_o)
    );

    wdk_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .run_i(run), .clr_i(feed), .tick_o(tick)
    );

    wdk_countdown #(.PULSE_CYC(PULSE_CYC), .INIT_COUNT(INIT_V)) u_cd (
        .clk(clk), .rst_n(rst_n), .feed_i(feed), .resume_i(resume),
        .halt_i(halt), .hold_i(hold), .tick_i(tick), .timeout_i(timeout),
        .count_o(count), .counting_o(counting), .run_o(run),
        .warn_o(warn), .expire_o(expire), .wd_rst_o(wd_rst_o)
    );

    wdk_count_mirror #(.SETTLE_CYC(SETTLE_CYC), .INIT_COUNT(INIT_V)) u_mirror (
        .clk(clk), .rst_n(rst_n), .live_i(count), .view_o(count_view)
    );

    // R7: the reset pulse starts on the edge that consumed a tick
    a_r7_fire_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_rst_o) |-> $past(tick));

    // R4: counting stops only right after the second stop key
    a_r4_stop_by_key: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(counting) |-> $past(bus_we && bus_addr == 6'h0C && bus_wdata == K_STOP_B));

    // R12: a frozen countdown produces no ticks
    a_r12_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_present && !keep) |-> !tick);
endmodule

// File: tb/wdk_watchdog_tb_top.sv
`timescale 1ns/1ps
module wdk_watchdog_tb_top;
    typedef struct {
        logic [15:0] val;
        string       req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        dbg_present = 1'b0;
    logic        wd_rst_o, irq_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;
    item_t exp_q[$];
    item_t act_q[$];

    always #2.5 clk = ~clk;

    wdk_watchdog #(.TICK_DIV(8), .PULSE_CYC(4), .SETTLE_CYC(3), .INIT_TMO(5)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_present(dbg_present),
        .wd_rst_o(wd_rst_o), .irq_o(irq_o)
    );

    // Driver side: push the expected and observed items
    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
        exp_q.push_back('{val: exp, req: req});
        act_q.push_back('{val: act, req: req});
    endtask

    // Monitor side: pop and compare
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0 && act_q.size() > 0) begin
                item_t e, a;
                e = exp_q.pop_front();
                a = act_q.pop_front();
                n_run++;
                if (a.val !== e.val) begin
                    n_fail++;
                    $display("FAIL %s: got 0x%04h expected 0x%04h", e.req, a.val, e.val);
                end
            end
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd_settled(output logic [15:0] d);
        for (int i = 0; i < 20; i++) begin
            rd(6'h14, d);
            if (!d[15]) break;
            step(1);
        end
    endtask

    task automatic report;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            report();
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        bit saw;
        step(4);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        check({15'd0, wd_rst_o}, 16'd0, "R1 rst low");
        check({15'd0, irq_o}, 16'd0, "R1 irq low");
        rd(6'h0C, d); check(d, 16'hDABE, "R1 stopped code");
        rd(6'h10, d); check(d, 16'h0000, "R1 status normal");
        rd(6'h04, d); check(d, 16'h0005, "R1 timeout init");
        rd(6'h14, d); check(d, 16'h0005, "R1 count init");
        rd(6'h18, d); check(d, 16'h0000, "R1 debug reg");

        // R3 timeout width
        wr(6'h04, 16'hFFFF);
        rd(6'h04, d); check(d, 16'h7FFF, "R3 bit15 dropped");

        // R2 wrong feed key ignored
        wr(6'h00, 16'hBEEF);
        rd_settled(d); check(d, 16'h0005, "R2 bad feed key");
        // R9 busy right after reload, R6 feed while stopped loads
        wr(6'h00, 16'hFEED);
        rd(6'h14, d); check({15'd0, d[15]}, 16'd1, "R9 busy after reload");
        rd_settled(d); check(d, 16'h7FFF, "R2 R6 feed loads");
        step(100);
        rd(6'h14, d); check(d, 16'h7FFF, "R6 no counting while stopped");

        // R6 resume without reload
        wr(6'h1C, 16'hACED);
        rd(6'h0C, d); check(d, 16'h0000, "R6 running code");
        rd(6'h14, d); check(d, 16'h7FFF, "R6 resume keeps count");
        step(40);
        rd_settled(d); check({15'd0, d < 16'h7FFF}, 16'd1, "R6 counting after resume");

        // R5 broken stop sequences
        wr(6'h00, 16'hFEED);
        wr(6'h0C, 16'hCAFE);
        rd(6'h0C, d); check(d, 16'h0000, "R5 lone second key");
        wr(6'h08, 16'h2BAD); wr(6'h08, 16'h1111); wr(6'h0C, 16'hCAFE);
        rd(6'h0C, d); check(d, 16'h0000, "R5 aborted by step-one write");
        wr(6'h08, 16'h2BAD); wr(6'h0C, 16'h0000); wr(6'h0C, 16'hCAFE);
        rd(6'h0C, d); check(d, 16'h0000, "R5 aborted by step-two write");

        // R4 proper stop
        wr(6'h08, 16'h2BAD); wr(6'h0C, 16'hCAFE);
        rd(6'h0C, d); check(d, 16'hDABE, "R4 stopped");
        check({15'd0, wd_rst_o}, 16'd0, "R4 no reset so far");

        // R7 R10 timed expiry with timeout 2
        wr(6'h24, 16'h0001);
        wr(6'h04, 16'h0002);
        wr(6'h1C, 16'hACED);
        wr(6'h00, 16'hFEED);
        step(15); check({15'd0, irq_o}, 16'd0, "R10 irq before warn");
        step(1);  check({15'd0, irq_o}, 16'd1, "R10 irq at warn tick");
        step(7);  check({15'd0, wd_rst_o}, 16'd0, "R7 no reset before expiry");
        step(1);  check({15'd0, wd_rst_o}, 16'd1, "R7 reset at expiry");
        step(3);  check({15'd0, wd_rst_o}, 16'd1, "R7 reset last cycle");
        step(1);  check({15'd0, wd_rst_o}, 16'd0, "R7 reset ended");
        wr(6'h08, 16'h2BAD); wr(6'h0C, 16'hCAFE);
        rd_settled(d); check(d, 16'h0002, "R7 reload to timeout");

        // R8 sticky status
        rd(6'h10, d); check(d, 16'hCFE8, "R8 expired code");
        wr(6'h10, 16'h1234);
        rd(6'h10, d); check(d, 16'hCFE8, "R8 wrong clear key");
        wr(6'h10, 16'hE8B4);
        rd(6'h10, d); check(d, 16'h0000, "R8 cleared");

        // R10 masking and acknowledge
        rd(6'h20, d); check(d, 16'h0001, "R10 event set");
        wr(6'h24, 16'h0000);
        check({15'd0, irq_o}, 16'd0, "R10 masked");
        wr(6'h20, 16'h0000);
        rd(6'h20, d); check(d, 16'h0001, "R10 zero write no ack");
        wr(6'h20, 16'h0001);
        rd(6'h20, d); check(d, 16'h0000, "R10 acked");

        // R11 force
        wr(6'h24, 16'h0001);
        check({15'd0, irq_o}, 16'd0, "R11 idle irq");
        wr(6'h28, 16'h0001);
        check({15'd0, irq_o}, 16'd1, "R11 forced");
        wr(6'h24, 16'h0000);
        check({15'd0, irq_o}, 16'd0, "R11 forced but masked");
        wr(6'h28, 16'h0000);
        wr(6'h24, 16'h0001);

        // R13 zero timeout
        wr(6'h04, 16'h0000);
        wr(6'h1C, 16'hACED);
        wr(6'h00, 16'hFEED);
        step(7); check({15'd0, wd_rst_o}, 16'd0, "R13 before first tick");
        step(1); check({15'd0, wd_rst_o}, 16'd1, "R13 expiry at first tick");
        check({15'd0, irq_o}, 16'd0, "R13 no warning");
        wr(6'h08, 16'h2BAD); wr(6'h0C, 16'hCAFE);
        wr(6'h10, 16'hE8B4);

        // R12 debug freeze
        step(6);
        wr(6'h04, 16'h0001);
        dbg_present = 1'b1;
        rd(6'h18, d); check(d, 16'h0002, "R12 debug visible");
        wr(6'h1C, 16'hACED);
        wr(6'h00, 16'hFEED);
        saw = 0;
        for (int i = 0; i < 40; i++) begin
            step(1);
            if (wd_rst_o) saw = 1;
        end
        check({15'd0, saw}, 16'd0, "R12 frozen no reset");
        rd_settled(d); check(d, 16'h0001, "R12 frozen count");
        wr(6'h18, 16'h0001);
        rd(6'h18, d); check(d, 16'h0003, "R12 keep bit");
        step(15); check({15'd0, wd_rst_o}, 16'd0, "R12 before expiry");
        step(1);  check({15'd0, wd_rst_o}, 16'd1, "R12 expiry with keep");
        dbg_present = 1'b0;
        wr(6'h08, 16'h2BAD); wr(6'h0C, 16'hCAFE);

        step(4);
        finished = 1;
        report();
        $finish;
    end
endmodule